// File: doc/BRIEF.md
# Peripheral Privilege Access Checker

This block sits on the bus path in front of a window of memory-mapped peripherals. For every access it works out which peripheral slot is targeted and whether the current master may reach it. Software keeps one bit per slot in a small register file. A set bit means that only privileged masters may use that slot. A non-privileged access to such a slot is stopped before it reaches the peripheral. The requester gets an error response, and a single fault flag is raised.

The check is purely combinational on the access path. A new permission setting therefore applies to the access in the cycle right after the register write. Out of reset every slot is open to everyone. The fault flag is handled through four views: a read-only flag, a write-1-to-set port, a write-1-to-clear port and an enable. The interrupt line is the flag gated by the enable. A read-only status register keeps the index of the slot that caused the first fault.

Top module: `periph_priv_guard`

## Requirements
- R1: After reset the privilege mask, the flag, the enable and the fault index are all zero, `irq` is low, and accesses of either privilege level are forwarded.
- R2: An access whose address is below 0x4000_0000 or above 0x4006_FFFF is forwarded unchanged and never faults.
- R3: Inside the window, the slot index is address bits [15:12] for addresses 0x4000_0000 to 0x4000_FFFF. Addresses from 0x4001_0000 to 0x4006_FFFF map to no slot and are always forwarded.
- R4: An access is blocked exactly when it is non-privileged (`req_priv`=0) and targets a slot whose mask bit is 1. Privileged accesses are never blocked.
- R5: A blocked access drives `per_valid` low, `rsp_err` high and `rsp_rdata` to zero. A forwarded access drives `per_valid` high and `rsp_err` low, and passes `per_rdata` through to `rsp_rdata`.
- R6: A mask write in one cycle governs an access presented in the next cycle, with no extra latency.
- R7: A blocked access sets the flag (register offset 1, bit 0) at the next edge. `irq` equals the flag ANDed with the enable (offset 4, bit 0).
- R8: A privileged write with bit 0 set to offset 2 sets the flag. The same write to offset 3 clears it. Writing 0 in bit 0 to either offset has no effect, and both offsets read as zero.
- R9: When a fault event and a clear write occur in the same cycle, the flag ends up set.
- R10: The fault index register (offset 5, bits [3:0]) captures the faulting slot only when an access fault raises the flag from 0 to 1. Otherwise it holds its value.
- R11: A non-privileged configuration write is ignored, leaving all registers unchanged, and it sets the flag. The mask sits at offset 0, bits [15:0], and is writable by privileged writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Upstream access valid |
| req_addr | input | 32 | Upstream access address |
| req_write | input | 1 | Upstream access is a write |
| req_wdata | input | 32 | Upstream write data |
| req_priv | input | 1 | Upstream access is privileged |
| rsp_rdata | output | 32 | Read data returned upstream |
| rsp_err | output | 1 | Access was blocked |
| per_valid | output | 1 | Access forwarded to peripheral |
| per_addr | output | 32 | Forwarded address |
| per_write | output | 1 | Forwarded write strobe |
| per_wdata | output | 32 | Forwarded write data |
| per_rdata | input | 32 | Peripheral read data |
| cfg_valid | input | 1 | Register access valid |
| cfg_write | input | 1 | Register access is a write |
| cfg_addr | input | 3 | Register word offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_priv | input | 1 | Register access is privileged |
| cfg_rdata | output | 32 | Register read data |
| irq | output | 1 | Privilege fault interrupt |

## Verification
The assertions check the following on every cycle:
- a blocked access is never forwarded and returns zero data;
- privileged and out-of-window accesses are never blocked;
- every block or non-privileged register write raises the flag at the next edge;
- set beats clear;
- the fault index cannot move while the flag is high.

Only the bench scenarios can show that the slot is decoded correctly and that the unmapped upper part of the window stays open. They also show that a mask write governs the very next access, and that the captured index matches the first faulting slot and not a later one.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
    localparam int NSLOT  = 16;
    localparam int SLOT_W = $clog2(NSLOT);
    localparam int CFG_AW = 3;

    typedef enum logic [CFG_AW-1:0] {
        OFF_MASK = 3'd0,
        OFF_FLAG = 3'd1,
        OFF_SET  = 3'd2,
        OFF_CLR  = 3'd3,
        OFF_EN   = 3'd4,
        OFF_IDX  = 3'd5
    } cfg_off_e;

    typedef struct packed {
        logic              in_win;
        logic              mapped;
        logic [SLOT_W-1:0] slot;
    } slot_dec_t;

    typedef struct packed {
        logic set_req;
        logic clr_req;
        logic bad_wr;
    } cfg_evt_t;

    function automatic logic slot_locked(input logic [NSLOT-1:0] mask,
                                         input slot_dec_t dec,
                                         input logic priv);
        return dec.mapped && !priv && mask[dec.slot];
    endfunction
endpackage

// File: rtl/ppg_decode.sv
module ppg_decode
    import ppg_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter logic [31:0] WIN_BASE   = 32'h4000_0000,
    parameter logic [31:0] WIN_LAST   = 32'h4006_FFFF,
    parameter int          SLOT_SHIFT = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output slot_dec_t         dec
);
    localparam logic [ADDR_W-1:0] BASE  = ADDR_W'(WIN_BASE);
    localparam logic [ADDR_W-1:0] LAST  = ADDR_W'(WIN_LAST);
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(NSLOT) << SLOT_SHIFT;

    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset     = addr - BASE;
        dec.in_win = (addr >= BASE) && (addr <= LAST);
        dec.mapped = dec.in_win && (offset < LIMIT);
        dec.slot   = offset[SLOT_SHIFT +: SLOT_W];
    end
endmodule

// File: rtl/ppg_cfg.sv
module ppg_cfg
    import ppg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_valid,
    input  logic              cfg_write,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              cfg_priv,
    output logic [NSLOT-1:0]  mask,
    output logic              en,
    output cfg_evt_t          evt
);
    logic wr_ok;

    always_comb begin
        wr_ok       = cfg_valid && cfg_write && cfg_priv;
        evt.bad_wr  = cfg_valid && cfg_write && !cfg_priv;
        evt.set_req = wr_ok && (cfg_addr == OFF_SET) && cfg_wdata[0];
        evt.clr_req = wr_ok && (cfg_addr == OFF_CLR) && cfg_wdata[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
            en   <= 1'b0;
        end else if (wr_ok) begin
            if (cfg_addr == OFF_MASK) mask <= cfg_wdata[NSLOT-1:0];
            if (cfg_addr == OFF_EN)   en   <= cfg_wdata[0];
        end
    end
endmodule

// File: rtl/ppg_irq.sv
module ppg_irq
    import ppg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_fault,
    input  logic [SLOT_W-1:0] acc_slot,
    input  cfg_evt_t          evt,
    output logic              flag,
    output logic [SLOT_W-1:0] idx
);
    logic hw_evt;
    logic flag_n;

    always_comb begin
        hw_evt = acc_fault || evt.bad_wr;
        // set sources are OR-ed after the clear so they take priority
        flag_n = (flag && !evt.clr_req) || evt.set_req || hw_evt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
            idx  <= '0;
        end else begin
            flag <= flag_n;
            if (!flag && acc_fault) idx <= acc_slot;
        end
    end
endmodule

// File: rtl/periph_priv_guard.sv
module periph_priv_guard
    import ppg_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          DATA_W     = 32,
    parameter logic [31:0] WIN_BASE   = 32'h4000_0000,
    parameter logic [31:0] WIN_LAST   = 32'h4006_FFFF,
    parameter int          SLOT_SHIFT = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_priv,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic              per_valid,
    output logic [ADDR_W-1:0] per_addr,
    output logic              per_write,
    output logic [DATA_W-1:0] per_wdata,
    input  logic [DATA_W-1:0] per_rdata,
    input  logic              cfg_valid,
    input  logic              cfg_write,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              cfg_priv,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              irq
);
    slot_dec_t         dec;
    logic [NSLOT-1:0]  mask_q;
    logic              en_q;
    cfg_evt_t          evt;
    logic              flag_q;
    logic [SLOT_W-1:0] idx_q;
    logic              blocked;

    ppg_decode #(
        .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_LAST(WIN_LAST), .SLOT_SHIFT(SLOT_SHIFT)
    ) u_dec (
        .addr(req_addr),
        .dec (dec)
    );

    ppg_cfg #(.DATA_W(DATA_W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .cfg_valid(cfg_valid),
        .cfg_write(cfg_write),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .cfg_priv (cfg_priv),
        .mask     (mask_q),
        .en       (en_q),
        .evt      (evt)
    );

    always_comb blocked = req_valid && slot_locked(mask_q, dec, req_priv);

    ppg_irq u_irq (
        .clk      (clk),
        .rst      (rst),
        .acc_fault(blocked),
        .acc_slot (dec.slot),
        .evt      (evt),
        .flag     (flag_q),
        .idx      (idx_q)
    );

    always_comb begin
        per_valid = req_valid && !blocked;
        per_addr  = req_addr;
        per_write = req_write;
        per_wdata = req_wdata;
        rsp_err   = blocked;
        rsp_rdata = blocked ? '0 : per_rdata;
        irq       = flag_q && en_q;
    end

    always_comb begin
        unique case (cfg_addr)
            OFF_MASK: cfg_rdata = DATA_W'(mask_q);
            OFF_FLAG: cfg_rdata = DATA_W'(flag_q);
            OFF_EN:   cfg_rdata = DATA_W'(en_q);
            OFF_IDX:  cfg_rdata = DATA_W'(idx_q);
            default:  cfg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ppg_guard_chk.sv
module ppg_guard_chk
    import ppg_pkg::*;
#(
    parameter int          ADDR_W   = 32,
    parameter int          DATA_W   = 32,
    parameter logic [31:0] WIN_BASE = 32'h4000_0000,
    parameter logic [31:0] WIN_LAST = 32'h4006_FFFF
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_priv,
    input logic              rsp_err,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              per_valid,
    input logic              cfg_valid,
    input logic              cfg_write,
    input logic [CFG_AW-1:0] cfg_addr,
    input logic [DATA_W-1:0] cfg_wdata,
    input logic              cfg_priv,
    input logic              flag,
    input logic [SLOT_W-1:0] idx,
    input logic [NSLOT-1:0]  mask
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) $fell(rst) |-> (mask == '0) && !flag && (idx == '0));

    // R5
    blocked_excl_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> !per_valid && (rsp_rdata == '0));

    // R4
    priv_pass_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_priv |-> !rsp_err && per_valid);

    // R2
    outside_pass_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && ((req_addr < ADDR_W'(WIN_BASE)) || (req_addr > ADDR_W'(WIN_LAST)))
        |-> per_valid && !rsp_err);

    // R7
    err_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_err |=> flag);

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_err && cfg_valid && cfg_write && cfg_priv && (cfg_addr == OFF_CLR) && cfg_wdata[0]
        |=> flag);

    // R10
    idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        flag |=> $stable(idx));

    // R11
    np_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_valid && cfg_write && !cfg_priv |=> flag && $stable(mask));
endmodule

bind periph_priv_guard ppg_guard_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_BASE(WIN_BASE), .WIN_LAST(WIN_LAST)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_addr (req_addr),
    .req_priv (req_priv),
    .rsp_err  (rsp_err),
    .rsp_rdata(rsp_rdata),
    .per_valid(per_valid),
    .cfg_valid(cfg_valid),
    .cfg_write(cfg_write),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .cfg_priv (cfg_priv),
    .flag     (flag_q),
    .idx      (idx_q),
    .mask     (mask_q)
);

// File: tb/test_periph_priv_guard.sv
`timescale 1ns/1ps
module test_periph_priv_guard;
    localparam real PERIOD = 8.0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 0, req_write = 0, req_priv = 0;
    logic [31:0] req_addr = '0, req_wdata = '0, per_rdata = '0;
    logic [31:0] rsp_rdata, per_addr, per_wdata, cfg_rdata;
    logic        rsp_err, per_valid, per_write, irq;
    logic        cfg_valid = 0, cfg_write = 0, cfg_priv = 0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] m_mask = '0;
    logic        m_flag = 0, m_en = 0;
    logic [3:0]  m_idx = '0;

    always #(PERIOD/2) clk = ~clk;

    periph_priv_guard i_periph_priv_guard (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .req_wdata(req_wdata), .req_priv(req_priv),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .per_valid(per_valid), .per_addr(per_addr), .per_write(per_write),
        .per_wdata(per_wdata), .per_rdata(per_rdata),
        .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_priv(cfg_priv), .cfg_rdata(cfg_rdata),
        .irq(irq)
    );

    function automatic bit f_mapped(input logic [31:0] a);
        return (a >= 32'h4000_0000) && (a <= 32'h4000_FFFF);
    endfunction

    function automatic logic [3:0] f_slot(input logic [31:0] a);
        return a[15:12];
    endfunction

    function automatic bit f_block(input bit av, input logic [31:0] a, input bit ap);
        return av && !ap && f_mapped(a) && m_mask[f_slot(a)];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One cycle: drive both buses at the falling edge, check the combinational
    // outputs, then advance the model across the rising edge.
    task automatic step(input bit av, input logic [31:0] a, input bit ap,
                        input bit cv, input logic [2:0] co, input logic [31:0] cd,
                        input bit cp, input string req);
        bit blk, setq, clrq, bad;
        @(negedge clk);
        req_valid = av; req_addr = a; req_priv = ap; req_write = a[2];
        req_wdata = ~a; per_rdata = a ^ 32'h5A5A_C3C3;
        cfg_valid = cv; cfg_write = cv; cfg_addr = co; cfg_wdata = cd; cfg_priv = cp;
        #1;
        blk = f_block(av, a, ap);
        chk(rsp_err == blk, req, {31'd0, rsp_err}, {31'd0, blk});
        chk(per_valid == (av && !blk), req, {31'd0, per_valid}, {31'd0, av && !blk});
        chk(rsp_rdata == (blk ? 32'd0 : per_rdata), req, rsp_rdata, blk ? 32'd0 : per_rdata);
        chk(irq == (m_flag && m_en), {req, "/R7 irq"}, {31'd0, irq}, {31'd0, m_flag && m_en});
        bad  = cv && !cp;
        setq = cv && cp && co == 3'd2 && cd[0];
        clrq = cv && cp && co == 3'd3 && cd[0];
        if (!m_flag && blk) m_idx = f_slot(a);
        m_flag = (m_flag && !clrq) || setq || blk || bad;
        if (cv && cp && co == 3'd0) m_mask = cd[15:0];
        if (cv && cp && co == 3'd4) m_en = cd[0];
        @(posedge clk);
    endtask

    task automatic idle;
        step(0, 32'h0, 0, 0, 3'd0, 32'h0, 0, "idle");
    endtask

    task automatic check_reg(input logic [2:0] off, input logic [31:0] exp, input string req);
        @(negedge clk);
        req_valid = 0; cfg_valid = 0; cfg_write = 0; cfg_addr = off;
        #1;
        chk(cfg_rdata == exp, req, cfg_rdata, exp);
    endtask

    task automatic check_model(input string req);
        check_reg(3'd0, {16'd0, m_mask}, {req, " mask"});
        check_reg(3'd1, {31'd0, m_flag}, {req, " flag"});
        check_reg(3'd4, {31'd0, m_en},   {req, " en"});
        check_reg(3'd5, {28'd0, m_idx},  {req, " idx"});
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1: reset state and open access
        check_model("R1");
        check_reg(3'd2, 32'd0, "R8 set reads zero");
        step(1, 32'h4000_3010, 0, 0, 3'd0, 0, 0, "R1 open nonpriv");
        step(1, 32'h4000_F000, 1, 0, 3'd0, 0, 0, "R1 open priv");

        // R6: mask write, then block on the next cycle
        step(0, 0, 0, 1, 3'd0, 32'h0000_0008, 1, "R6 write mask");
        step(1, 32'h4000_3004, 0, 0, 3'd0, 0, 0, "R6 R4 R5 block slot3");
        check_model("R7 R10 first fault");
        step(1, 32'h4000_3004, 1, 0, 3'd0, 0, 0, "R4 priv passes");
        step(1, 32'h4000_2FFC, 0, 0, 3'd0, 0, 0, "R3 neighbour slot2");

        // R3 / R2: unmapped part of window and outside
        step(1, 32'h4001_3000, 0, 0, 3'd0, 0, 0, "R3 unmapped window");
        step(1, 32'h4006_FFFC, 0, 0, 3'd0, 0, 0, "R3 window top");
        step(1, 32'h4007_3000, 0, 0, 3'd0, 0, 0, "R2 above window");
        step(1, 32'h3FFF_3000, 0, 0, 3'd0, 0, 0, "R2 below window");

        // R10: second fault while flag high keeps index
        step(0, 0, 0, 1, 3'd0, 32'h0000_0028, 1, "R6 mask 3,5");
        step(1, 32'h4000_5000, 0, 0, 3'd0, 0, 0, "R10 second fault");
        check_model("R10 hold");

        // R7 / R8
        step(0, 0, 0, 1, 3'd4, 32'h1, 1, "R7 enable");
        idle;
        step(0, 0, 0, 1, 3'd3, 32'h2, 1, "R8 clear bit0 zero");
        check_model("R8 no effect");
        step(0, 0, 0, 1, 3'd3, 32'h1, 1, "R8 clear");
        idle;
        check_model("R8 cleared");
        step(0, 0, 0, 1, 3'd2, 32'h1, 1, "R8 set");
        idle;
        check_model("R8 R10 set keeps idx");
        step(0, 0, 0, 1, 3'd3, 32'h1, 1, "R8 clear again");

        // R9: fault and clear together
        step(1, 32'h4000_5008, 0, 1, 3'd3, 32'h1, 1, "R9 set wins");
        idle;
        check_model("R9 R10 capture slot5");
        step(0, 0, 0, 1, 3'd3, 32'h1, 1, "R9 clear");

        // R11: non-privileged register write
        step(0, 0, 0, 1, 3'd0, 32'h0, 0, "R11 np mask write");
        idle;
        check_model("R11 ignored");
        step(1, 32'h4000_3000, 0, 0, 3'd0, 0, 0, "R11 still blocked");
        step(0, 0, 0, 1, 3'd3, 32'h1, 1, "R11 clear");

        // randomized traffic
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            bit av, ap, cv, cp;
            logic [2:0] co;
            logic [31:0] cd;
            a  = ($urandom % 8 == 0) ? $urandom : (32'h4000_0000 | ($urandom % 32'h0007_0000));
            av = $urandom % 4 != 0;
            ap = $urandom % 3 == 0;
            cv = $urandom % 4 == 0;
            cp = $urandom % 5 != 0;
            co = 3'($urandom % 6);
            cd = $urandom;
            step(av, a, ap, cv, co, cd, cp, "R4 R5 R6 random");
            if (i % 50 == 49) check_model("R10 R11 random regs");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule